// File: doc/BRIEF.md
# Oscillator-to-Pulse-Command PWM Handoff

This block produces the on/off command for a power switch on the primary side of an isolated converter. After reset it runs from its own free-running oscillator. Every oscillator period it turns the switch on, and a duty clamp together with a soft-start on-time cap turns it off again. The secondary-side controller sends its own switching decisions across an isolation barrier as short start and stop pulses. These arrive here as digital levels that have already been thresholded. Each pulse is checked for width, measured in clock cycles. The first stop pulse that passes this check moves control of the switch to the external pulses. Control stays there until a soft-start restart hands it back to the oscillator.

The output is a set/reset latch in which reset always wins. Its reset side is the OR of the following:
- a fault bundle;
- the restart request;
- a stop command;
- a zero soft-start cap;
- the on-time limit.

Once the block is synchronized, each accepted start restarts the oscillator phase. The same on-time limit then bounds the external commands. The oscillator tick is also brought out.

Top module: `pwmHandoff`

## Requirements
- R1: While `rstN` is low, `gateOut` is 0, `synced` is 0 and `oscTick` is 1 (the oscillator phase counter sits at zero).
- R2: When unsynchronized, `oscTick` is high for one cycle every `periodCfg` cycles, and `gateOut` rises in the cycle after a tick cycle unless a reset cause is present in the tick cycle.
- R3: Each on-time lasts at most L cycles, where L = min(floor(18*`periodCfg`/25), `ssLimit`). This is the 72% clamp and the soft-start cap, and it applies in both control modes. With no other reset cause, the on-time is exactly L.
- R4: While `ssLimit` is 0, `gateOut` is 0 in the next cycle, and a start pulse or tick cannot turn it on.
- R5: A pulse counts only if its number of consecutive high cycles N satisfies `minWidth` <= N <= `maxWidth`. Its effect on `gateOut` or `synced` appears two clock edges after the first edge at which the pulse input is sampled low. Pulses outside the window have no effect.
- R6: An accepted stop pulse turns `gateOut` off and sets `synced`. While `synced` is 1, oscillator ticks no longer turn the output on.
- R7: While `synced` is 1, an accepted start pulse turns `gateOut` on if it is off, and restarts the oscillator phase.
- R8: Any set bit of `faultVec` forces `gateOut` to 0 in the next cycle and leaves `synced` unchanged.
- R9: `handoffClear` forces `gateOut` to 0 and `synced` to 0 in the next cycle, after which oscillator ticks turn the output on again.
- R10: A set request and a reset request in the same cycle leave `gateOut` at 0.
- R11: An accepted stop and `handoffClear` in the same cycle leave `synced` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Thresholded start (turn-on) pulse level |
| stopPulse | input | 1 | Thresholded stop (turn-off) pulse level |
| minWidth | input | WW | Minimum accepted pulse width in cycles |
| maxWidth | input | WW | Maximum accepted pulse width in cycles |
| ssLimit | input | PW | Soft-start on-time cap in cycles; 0 blocks turn-on |
| faultVec | input | NF | Fault terminations, any bit forces the output off |
| handoffClear | input | 1 | Soft-start restart: output off, return to oscillator |
| periodCfg | input | PW | Oscillator period in cycles (4 or more) |
| gateOut | output | 1 | Power-switch on/off command |
| synced | output | 1 | High while external pulses have control |
| oscTick | output | 1 | One-cycle oscillator period marker |

## Verification
The block is driven in free-running mode with several periods and soft-start caps. This shows whether the tick period and the clamped on-time follow their formulas. Stop pulses of widths below, inside and above the acceptance window separate correct width qualification from an off-by-one at either bound. Directed collisions set a tick against a fault, and a stop against the restart request, to expose any wrong priority between the latch inputs. A long random mix of both pulse channels, faults, restarts, cap changes and period changes is compared cycle by cycle with a reference model. This catches errors in the handoff and in the phase restart that only show up when events overlap.

// File: rtl/pwmHandoffPkg.sv
package pwmHandoffPkg;
  // Strobes from control into the datapath latch
  typedef struct packed {
    logic setReq;
    logic rstReq;
  } gateCmd_t;

  // Status from the datapath back to control
  typedef struct packed {
    logic oscTick;
    logic limitHit;
  } dpStat_t;
endpackage

// File: rtl/pwmPulseQual.sv
module pwmPulseQual #(
  parameter int WW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pulseIn,
  input  logic [WW-1:0] minW,
  input  logic [WW-1:0] maxW,
  output logic          evOut
);
  localparam logic [WW-1:0] SAT = '1;

  logic [WW-1:0] wCnt;

  // wCnt holds the number of high cycles seen so far; it saturates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wCnt  <= '0;
      evOut <= 1'b0;
    end else begin
      evOut <= !pulseIn && (wCnt != '0) && (wCnt >= minW) && (wCnt <= maxW);
      if (!pulseIn)         wCnt <= '0;
      else if (wCnt != SAT) wCnt <= wCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwmHandoffDatapath.sv
module pwmHandoffDatapath
  import pwmHandoffPkg::*;
#(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [PW-1:0] periodCfg,
  input  logic [PW-1:0] ssLimit,
  input  gateCmd_t      cmd,
  output dpStat_t       stat,
  output logic          gateOut
);
  localparam int CW = PW + 5;

  logic [PW-1:0] phaseCnt;
  logic [CW-1:0] clampProd;
  logic [PW-1:0] clampCycles;
  logic [PW-1:0] onLimit;
  logic          gateQ;
  logic          setTaken;

  // 72% of the period, rounded down
  assign clampProd   = {5'd0, periodCfg} * CW'(18);
  assign clampCycles = PW'(clampProd / CW'(25));
  assign onLimit     = (ssLimit < clampCycles) ? ssLimit : clampCycles;

  assign setTaken      = cmd.setReq && !cmd.rstReq && !gateQ;
  assign stat.oscTick  = (phaseCnt == '0);
  assign stat.limitHit = gateQ && (phaseCnt >= onLimit);
  assign gateOut       = gateQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      gateQ    <= 1'b0;
    end else begin
      if (setTaken)                               phaseCnt <= PW'(1);
      else if (phaseCnt >= periodCfg - PW'(1))    phaseCnt <= '0;
      else                                        phaseCnt <= phaseCnt + 1'b1;

      if (cmd.rstReq)      gateQ <= 1'b0;
      else if (cmd.setReq) gateQ <= 1'b1;
    end
  end
endmodule

// File: rtl/pwmHandoffCtrl.sv
module pwmHandoffCtrl
  import pwmHandoffPkg::*;
#(
  parameter int PW = 12,
  parameter int NF = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startEv,
  input  logic          stopEv,
  input  logic [NF-1:0] faultVec,
  input  logic          handoffClear,
  input  logic [PW-1:0] ssLimit,
  input  dpStat_t       stat,
  output gateCmd_t      cmd,
  output logic          syncQ
);
  // The restart request beats a stop in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             syncQ <= 1'b0;
    else if (handoffClear) syncQ <= 1'b0;
    else if (stopEv)       syncQ <= 1'b1;
  end

  always_comb begin
    cmd.setReq = syncQ ? startEv : stat.oscTick;
    cmd.rstReq = (|faultVec) || handoffClear || stopEv || stat.limitHit
                 || (ssLimit == '0);
  end
endmodule

// File: rtl/pwmHandoff.sv
module pwmHandoff
  import pwmHandoffPkg::*;
#(
  parameter int PW = 12,
  parameter int WW = 6,
  parameter int NF = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic          stopPulse,
  input  logic [WW-1:0] minWidth,
  input  logic [WW-1:0] maxWidth,
  input  logic [PW-1:0] ssLimit,
  input  logic [NF-1:0] faultVec,
  input  logic          handoffClear,
  input  logic [PW-1:0] periodCfg,
  output logic          gateOut,
  output logic          synced,
  output logic          oscTick
);
  localparam int NCH = 2;  // channel 0 = start, channel 1 = stop

  logic [NCH-1:0] pulseVec;
  logic [NCH-1:0] evVec;
  gateCmd_t       cmd;
  dpStat_t        stat;

  assign pulseVec = {stopPulse, startPulse};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_qual
    pwmPulseQual #(.WW(WW)) qual_i (
      .clk    (clk),
      .rstN   (rstN),
      .pulseIn(pulseVec[ch]),
      .minW   (minWidth),
      .maxW   (maxWidth),
      .evOut  (evVec[ch])
    );
  end

  pwmHandoffCtrl #(.PW(PW), .NF(NF)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startEv     (evVec[0]),
    .stopEv      (evVec[1]),
    .faultVec    (faultVec),
    .handoffClear(handoffClear),
    .ssLimit     (ssLimit),
    .stat        (stat),
    .cmd         (cmd),
    .syncQ       (synced)
  );

  pwmHandoffDatapath #(.PW(PW)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .periodCfg(periodCfg),
    .ssLimit  (ssLimit),
    .cmd      (cmd),
    .stat     (stat),
    .gateOut  (gateOut)
  );

  assign oscTick = stat.oscTick;
endmodule

// File: rtl/pwmHandoffChk.sv
module pwmHandoffChk #(
  parameter int PW = 12,
  parameter int NF = 7
) (
  input logic          clk,
  input logic          rstN,
  input logic          gateOut,
  input logic          synced,
  input logic [NF-1:0] faultVec,
  input logic          handoffClear,
  input logic [PW-1:0] ssLimit,
  input logic [PW-1:0] periodCfg,
  input logic          startEv,
  input logic          stopEv
);
  logic [PW:0] runLen;
  int          clampNow;

  assign clampNow = (int'(periodCfg) * 18) / 25;

  // Number of consecutive high cycles before the current one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        runLen <= '0;
    else if (!gateOut) runLen <= '0;
    else if (runLen != '1) runLen <= runLen + 1'b1;
  end

  p_fault_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|faultVec) |=> !gateOut);

  p_zero_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ssLimit == '0) |=> !gateOut);

  p_clear_unsync_r9: assert property (@(posedge clk) disable iff (!rstN)
    handoffClear |=> !synced);

  p_clamp_r3: assert property (@(posedge clk) disable iff (!rstN)
    (gateOut && (int'(runLen) + 1 >= clampNow)) |=> !gateOut);

  p_sync_by_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(synced) |-> $past(stopEv));

  p_sync_turn_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(gateOut) && $past(synced)) |-> $past(startEv));
endmodule

bind pwmHandoff pwmHandoffChk #(.PW(PW), .NF(NF)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .gateOut     (gateOut),
  .synced      (synced),
  .faultVec    (faultVec),
  .handoffClear(handoffClear),
  .ssLimit     (ssLimit),
  .periodCfg   (periodCfg),
  .startEv     (evVec[0]),
  .stopEv      (evVec[1])
);

// File: tb/pwmHandoff_tb_top.sv
module pwmHandoff_tb_top;
  localparam int PW = 12;
  localparam int WW = 6;
  localparam int NF = 7;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic          stopPulse = 1'b0;
  logic [WW-1:0] minWidth = WW'(2);
  logic [WW-1:0] maxWidth = WW'(8);
  logic [PW-1:0] ssLimit = PW'(4095);
  logic [NF-1:0] faultVec = '0;
  logic          handoffClear = 1'b0;
  logic [PW-1:0] periodCfg = PW'(20);
  logic          gateOut, synced, oscTick;

  int unsigned totalChecks = 0;
  int unsigned badChecks = 0;
  int unsigned cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmHandoff #(.PW(PW), .WW(WW), .NF(NF)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopPulse(stopPulse),
    .minWidth(minWidth), .maxWidth(maxWidth), .ssLimit(ssLimit),
    .faultVec(faultVec), .handoffClear(handoffClear), .periodCfg(periodCfg),
    .gateOut(gateOut), .synced(synced), .oscTick(oscTick)
  );

  function automatic int expLimit(int p, int s);
    int c = (p * 18) / 25;
    return (s < c) ? s : c;
  endfunction

  function automatic logic inWindow(int w);
    return (w != 0) && (w >= int'(minWidth)) && (w <= int'(maxWidth));
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    totalChecks++;
    if (!ok) begin
      badChecks++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---- reference model built from the requirements ----
  int   mCnt, mStartW, mStopW;
  logic mGate, mSync, mStartEv, mStopEv;
  logic mSet, mRst;

  always_comb begin
    mSet = mSync ? mStartEv : (mCnt == 0);
    mRst = (|faultVec) || handoffClear || mStopEv || (ssLimit == '0)
           || (mGate && (mCnt >= expLimit(int'(periodCfg), int'(ssLimit))));
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= 0; mGate <= 1'b0; mSync <= 1'b0;
      mStartW <= 0; mStopW <= 0; mStartEv <= 1'b0; mStopEv <= 1'b0;
    end else begin
      mStartEv <= !startPulse && inWindow(mStartW);
      mStopEv  <= !stopPulse && inWindow(mStopW);
      mStartW  <= startPulse ? ((mStartW < 63) ? mStartW + 1 : 63) : 0;
      mStopW   <= stopPulse ? ((mStopW < 63) ? mStopW + 1 : 63) : 0;
      if (mSet && !mRst && !mGate)            mCnt <= 1;
      else if (mCnt >= int'(periodCfg) - 1)   mCnt <= 0;
      else                                    mCnt <= mCnt + 1;
      if (mRst)      mGate <= 1'b0;
      else if (mSet) mGate <= 1'b1;
      if (handoffClear) mSync <= 1'b0;
      else if (mStopEv) mSync <= 1'b1;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(gateOut == mGate, "R2 R3 R7 model gateOut", int'(gateOut), int'(mGate));
      chk(synced == mSync, "R6 R9 model synced", int'(synced), int'(mSync));
      chk(oscTick == (mCnt == 0), "R2 R7 model oscTick", int'(oscTick), int'(mCnt == 0));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      badChecks++;
      totalChecks++;
      $display("FAIL watchdog expired actual=%0d expected=<200000", cycles);
      $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
      $finish;
    end
  end

  // Drive a pulse of w high cycles; returns at the negedge where it drops
  task automatic sendPulse(input bit isStop, input int w);
    if (isStop) stopPulse = 1'b1; else startPulse = 1'b1;
    repeat (w) @(negedge clk);
    stopPulse = 1'b0;
    startPulse = 1'b0;
  endtask

  task automatic measureRun(output int run);
    run = 0;
    while (gateOut) begin
      run++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n, run, seen;
    void'($urandom(32'd4242));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(gateOut == 1'b0, "R1 gateOut in reset", int'(gateOut), 0);
    chk(synced == 1'b0, "R1 synced in reset", int'(synced), 0);
    chk(oscTick == 1'b1, "R1 oscTick in reset", int'(oscTick), 1);
    rstN = 1'b1;

    // R2: tick period and turn-on after the tick
    @(negedge clk);
    chk(gateOut == 1'b1, "R2 gate on after tick", int'(gateOut), 1);
    n = 1;
    while (!oscTick) begin @(negedge clk); n++; end
    chk(n == 20, "R2 tick period", n, 20);

    // R3: clamp-limited then cap-limited on-time
    @(negedge clk);
    measureRun(run);
    chk(run == 14, "R3 on-time at 72% clamp", run, 14);
    ssLimit = PW'(5);
    while (!gateOut) @(negedge clk);
    measureRun(run);
    chk(run == 5, "R3 on-time at soft-start cap", run, 5);
    ssLimit = PW'(4095);

    // R5: width window on the stop channel
    sendPulse(1'b1, 1); repeat (2) @(negedge clk);
    chk(synced == 1'b0, "R5 too-short stop ignored", int'(synced), 0);
    sendPulse(1'b1, 9); repeat (2) @(negedge clk);
    chk(synced == 1'b0, "R5 too-long stop ignored", int'(synced), 0);
    sendPulse(1'b1, 2); repeat (2) @(negedge clk);
    chk(synced == 1'b1, "R5 R6 min-width stop accepted", int'(synced), 1);
    chk(gateOut == 1'b0, "R6 stop turns gate off", int'(gateOut), 0);

    // R6: ticks no longer turn the output on
    seen = 0;
    repeat (60) begin @(negedge clk); if (gateOut) seen++; end
    chk(seen == 0, "R6 no oscillator turn-on when synced", seen, 0);

    // R7: start turns on, clamp still applies
    sendPulse(1'b0, 4); repeat (2) @(negedge clk);
    chk(gateOut == 1'b1, "R7 start turns gate on", int'(gateOut), 1);
    measureRun(run);
    chk(run == 14, "R7 R3 clamp after handoff", run, 14);

    // R4: zero cap blocks a start
    ssLimit = '0;
    sendPulse(1'b0, 4); repeat (2) @(negedge clk);
    seen = 0;
    repeat (6) begin if (gateOut) seen++; @(negedge clk); end
    chk(seen == 0, "R4 zero cap blocks start", seen, 0);
    ssLimit = PW'(4095);

    // R8: fault forces off, keeps sync
    sendPulse(1'b0, 3); repeat (2) @(negedge clk);
    chk(gateOut == 1'b1, "R8 precondition gate on", int'(gateOut), 1);
    faultVec = NF'(1) << 3;
    @(negedge clk);
    faultVec = '0;
    chk(gateOut == 1'b0, "R8 fault forces off", int'(gateOut), 0);
    chk(synced == 1'b1, "R8 sync kept on fault", int'(synced), 1);

    // R9: restart returns control to the oscillator
    handoffClear = 1'b1;
    @(negedge clk);
    handoffClear = 1'b0;
    chk(synced == 1'b0, "R9 clear drops sync", int'(synced), 0);
    seen = 0;
    repeat (22) begin @(negedge clk); if (gateOut) seen++; end
    chk(seen != 0, "R9 oscillator resumes", seen, 1);

    // R11: stop and clear in the same cycle
    sendPulse(1'b1, 3);
    @(negedge clk);
    handoffClear = 1'b1;
    @(negedge clk);
    handoffClear = 1'b0;
    chk(synced == 1'b0, "R11 clear beats stop", int'(synced), 0);

    // R10: tick and fault in the same cycle
    while (!oscTick) @(negedge clk);
    faultVec = NF'(1);
    @(negedge clk);
    faultVec = '0;
    chk(gateOut == 1'b0, "R10 reset wins over set", int'(gateOut), 0);

    // Random mix checked by the model
    for (int it = 0; it < 400; it++) begin
      int k = int'($urandom_range(0, 11));
      if (k < 4)       sendPulse(1'b0, int'($urandom_range(1, 11)));
      else if (k < 7)  sendPulse(1'b1, int'($urandom_range(1, 11)));
      else if (k == 7) begin
        faultVec = NF'(1) << $urandom_range(0, NF - 1);
        @(negedge clk);
        faultVec = '0;
      end
      else if (k == 8) begin
        handoffClear = 1'b1;
        @(negedge clk);
        handoffClear = 1'b0;
      end
      else if (k == 9)  ssLimit = PW'($urandom_range(0, 18));
      else if (k == 10) ssLimit = PW'(4095);
      else              periodCfg = PW'($urandom_range(8, 40));
      repeat (int'($urandom_range(1, 25))) @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  end
endmodule